// File: doc/BRIEF.md
# Serial Transmitter with Per-Frame Completion Actions

This block is a serial transmit engine with a two-entry frame buffer. A single 32-bit store loads two frames at once. Each frame carries five control flags that take effect only when that frame's stop bit ends. The flags can send the frame as a break, release the output driver to tristate, switch the transmitter off, switch the receiver on, or pulse a clear to the receiver's block status.

Software writes a 32-bit word into the block. The low half holds the first frame and the high half holds the second. The block shifts the frames out one bit per baud tick and applies each frame's flags as that frame finishes. Baud-rate generation and the receiver itself live outside the block. The block only drives the receiver enable level and the unblock pulse.

Top module: `uart_postact_tx`

## Requirements
- R1: After reset, `tx_line` is 1, and `tx_oe`, `tx_en`, `rx_en`, `rx_unblock` and `overflow` are 0.
- R2: A one-cycle `tx_en_cmd` pulse sets `tx_en` and clears the tristate state from the next cycle on. `tx_oe` is high exactly when `tx_en` is set and the tristate state is clear.
- R3: A write is accepted only when no frame is waiting in the buffer. The frame currently shifting does not count. An accepted write queues the low frame (data in bits 8:0) ahead of the high frame (data in bits 24:16). Any other write is dropped and sets the sticky `overflow` output.
- R4: A frame starts on a baud tick while `tx_en` is set and a frame is queued. The frame is one low start bit, then 8 data bits (`nine_bit`=0) or 9 data bits (`nine_bit`=1) sent LSB first, then one high stop bit. Each bit lasts from one tick to the next.
- R5: Bit 13 (low frame) or bit 29 (high frame) is the break flag. It drives that frame's stop bit low, and the data bits go out unchanged.
- R6: Bit 12 or bit 28 is the tristate flag. It sets the tristate state when the frame completes, so `tx_oe` drops while `tx_en` stays set.
- R7: Bit 11 or bit 27 is the unblock flag. It produces a one-cycle `rx_unblock` pulse in the cycle after the completing tick.
- R8: Bit 15 or bit 31 is the receive-enable flag. It sets `rx_en` when the frame completes, and `rx_en` then stays high until reset.
- R9: Bit 14 or bit 30 is the transmit-disable flag. It clears `tx_en`, and therefore `tx_oe`, when the frame completes. Queued frames stay in the buffer and do not start until `tx_en_cmd` is pulsed.
- R10: All completion actions become visible in the clock cycle after the tick that ends the stop bit. If a frame is queued and transmission is still enabled, the next start bit begins on that same tick.
- R11: Bits 10:9 and 26:25 are reserved and have no effect on the line or on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the dual-frame word |
| wr_data | input | 32 | Two frames with flags: low half first |
| baud_tick | input | 1 | One-cycle pulse marking bit boundaries |
| nine_bit | input | 1 | Static: 1 selects 9 data bits, 0 selects 8 |
| tx_en_cmd | input | 1 | Pulse: enable transmitter, clear tristate |
| tx_line | output | 1 | Serial data, idle high |
| tx_oe | output | 1 | Output-driver enable for tx_line |
| tx_en | output | 1 | Transmitter enable state |
| rx_en | output | 1 | Receiver enable level |
| rx_unblock | output | 1 | One-cycle pulse clearing the receiver block status |
| overflow | output | 1 | Sticky: a write was dropped |

## Verification
On every cycle, the assertions check several invariants:
- `tx_line` changes only after a baud tick.
- `tx_en` falls only on a tick and rises only after a command.
- `tx_oe` never stands without `tx_en`.
- `rx_en` and `overflow` never fall.
- `rx_unblock` never lasts more than one cycle.

Only the bench scenarios can show the bit order and the stop-bit value of break frames. They also show that each action is bound to the frame that carries it rather than its neighbour, that a disabled transmitter holds the second queued frame until it is re-enabled, and that reserved bits change nothing.

// File: rtl/uart_pa_pkg.sv
package uart_pa_pkg;
    localparam int DATA_W   = 9;
    localparam int HALF_W   = 16;
    localparam int BUF_DEPTH = 2;
    localparam int CNT_W    = $clog2(DATA_W + 2);
    localparam int BCNT_W   = $clog2(BUF_DEPTH + 1);

    // Flag positions within one 16-bit half of the write word.
    localparam int POS_RXON  = 15;
    localparam int POS_TXOFF = 14;
    localparam int POS_BRK   = 13;
    localparam int POS_TRI   = 12;
    localparam int POS_UNBLK = 11;

    typedef struct packed {
        logic              rx_on;
        logic              tx_off;
        logic              brk;
        logic              tri_st;
        logic              unblk;
        logic [DATA_W-1:0] data;
    } frame_t;

    function automatic frame_t unpack_half(input logic [HALF_W-1:0] h);
        frame_t f;
        f.rx_on  = h[POS_RXON];
        f.tx_off = h[POS_TXOFF];
        f.brk    = h[POS_BRK];
        f.tri_st = h[POS_TRI];
        f.unblk  = h[POS_UNBLK];
        f.data   = h[DATA_W-1:0];
        return f;
    endfunction
endpackage

// File: rtl/uart_pa_buf.sv
module uart_pa_buf
    import uart_pa_pkg::*;
#(
    parameter int DEPTH = BUF_DEPTH
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   push_pair,
    input  frame_t lo_frame,
    input  frame_t hi_frame,
    input  logic   pop,
    output frame_t head,
    output logic   empty
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        frame_t [DEPTH-1:0] slot;
        logic   [CW-1:0]    cnt;
    } buf_t;

    buf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pop && st_q.cnt != '0) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                st_d.slot[i] = st_q.slot[i+1];
            end
            st_d.slot[DEPTH-1] = '0;
            st_d.cnt = st_q.cnt - 1'b1;
        end else if (push_pair && st_q.cnt == '0) begin
            st_d.slot[0] = lo_frame;
            st_d.slot[1] = hi_frame;
            st_d.cnt     = CW'(2);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.slot[0];
    assign empty = (st_q.cnt == '0);
endmodule

// File: rtl/uart_pa_shift.sv
module uart_pa_shift
    import uart_pa_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick,
    input  logic   nine_bit,
    input  logic   load,
    input  frame_t frame_in,
    output logic   busy,
    output logic   line,
    output logic   done,
    output frame_t cur_frame
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        frame_t           fr;
    } sh_t;

    sh_t sh_d, sh_q;
    logic [CNT_W-1:0] last_idx;
    logic [CNT_W-1:0] bit_idx;

    assign last_idx = nine_bit ? CNT_W'(DATA_W + 1) : CNT_W'(DATA_W);
    assign bit_idx  = sh_q.cnt - 1'b1;
    assign done     = tick && sh_q.busy && (sh_q.cnt == last_idx);

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d.busy = 1'b1;
            sh_d.cnt  = '0;
            sh_d.fr   = frame_in;
        end else if (done) begin
            sh_d.busy = 1'b0;
            sh_d.cnt  = '0;
        end else if (tick && sh_q.busy) begin
            sh_d.cnt = sh_q.cnt + 1'b1;
        end
    end

    always_comb begin
        if (!sh_q.busy)                line = 1'b1;
        else if (sh_q.cnt == '0)       line = 1'b0;
        else if (sh_q.cnt == last_idx) line = ~sh_q.fr.brk;
        else                           line = sh_q.fr.data[bit_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign busy      = sh_q.busy;
    assign cur_frame = sh_q.fr;
endmodule

// File: rtl/uart_postact_tx.sv
module uart_postact_tx
    import uart_pa_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        baud_tick,
    input  logic        nine_bit,
    input  logic        tx_en_cmd,
    output logic        tx_line,
    output logic        tx_oe,
    output logic        tx_en,
    output logic        rx_en,
    output logic        rx_unblock,
    output logic        overflow
);
    typedef struct packed {
        logic tx_en;
        logic tri_st;
        logic rx_en;
        logic unblk;
        logic ovf;
    } ctl_t;

    ctl_t   ctl_d, ctl_q;
    frame_t head, cur_fr;
    logic   buf_empty, sh_busy, sh_done, sh_line;
    logic   accept, load, en_eff;

    assign accept = wr_en && buf_empty;
    assign en_eff = ctl_q.tx_en && !(sh_done && cur_fr.tx_off);
    assign load   = baud_tick && en_eff && !buf_empty && (!sh_busy || sh_done);

    uart_pa_buf #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_pair(accept),
        .lo_frame (unpack_half(wr_data[HALF_W-1:0])),
        .hi_frame (unpack_half(wr_data[2*HALF_W-1:HALF_W])),
        .pop      (load),
        .head     (head),
        .empty    (buf_empty)
    );

    uart_pa_shift u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (baud_tick),
        .nine_bit (nine_bit),
        .load     (load),
        .frame_in (head),
        .busy     (sh_busy),
        .line     (sh_line),
        .done     (sh_done),
        .cur_frame(cur_fr)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.unblk = 1'b0;
        if (sh_done) begin
            if (cur_fr.tri_st) ctl_d.tri_st = 1'b1;
            if (cur_fr.unblk)  ctl_d.unblk  = 1'b1;
            if (cur_fr.rx_on)  ctl_d.rx_en  = 1'b1;
            if (cur_fr.tx_off) ctl_d.tx_en  = 1'b0;
        end
        if (wr_en && !buf_empty) ctl_d.ovf = 1'b1;
        if (tx_en_cmd) begin
            ctl_d.tx_en  = 1'b1;
            ctl_d.tri_st = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign tx_line    = sh_line;
    assign tx_oe      = ctl_q.tx_en && !ctl_q.tri_st;
    assign tx_en      = ctl_q.tx_en;
    assign rx_en      = ctl_q.rx_en;
    assign rx_unblock = ctl_q.unblk;
    assign overflow   = ctl_q.ovf;
endmodule

// File: rtl/uart_postact_tx_chk.sv
module uart_postact_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic tx_en_cmd,
    input logic tx_line,
    input logic tx_oe,
    input logic tx_en,
    input logic rx_en,
    input logic rx_unblock,
    input logic overflow
);
    // R4
    line_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(baud_tick) |-> $stable(tx_line));

    // R2
    oe_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_oe |-> tx_en);

    // R2
    en_rise_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> $past(tx_en_cmd));

    // R9
    en_fall_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_en) |-> $past(baud_tick));

    // R8
    rx_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en |=> rx_en);

    // R7
    unblock_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_unblock |=> !rx_unblock);

    // R3
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

bind uart_postact_tx uart_postact_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .tx_en_cmd (tx_en_cmd),
    .tx_line   (tx_line),
    .tx_oe     (tx_oe),
    .tx_en     (tx_en),
    .rx_en     (rx_en),
    .rx_unblock(rx_unblock),
    .overflow  (overflow)
);

// File: tb/uart_postact_tx_tb.sv
`timescale 1ns/1ps
module uart_postact_tx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        baud_tick = 1'b0;
    logic        nine_bit = 1'b0;
    logic        tx_en_cmd = 1'b0;
    logic        tx_line, tx_oe, tx_en, rx_en, rx_unblock, overflow;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    tick_cnt = 0;
    bit    running = 0;
    bit    finished = 0;
    string line_req = "R4";

    always #5 clk = ~clk;

    uart_postact_tx u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .baud_tick(baud_tick), .nine_bit(nine_bit), .tx_en_cmd(tx_en_cmd),
        .tx_line(tx_line), .tx_oe(tx_oe), .tx_en(tx_en), .rx_en(rx_en),
        .rx_unblock(rx_unblock), .overflow(overflow)
    );

    // Behavioural reference: a queue of 16-bit halves and integer bit position.
    int q[$];
    int cur = 0;
    int pos = 0;
    bit busy = 0;
    bit m_txen = 0, m_tri = 0, m_rx = 0, m_unb = 0, m_ovf = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            cur = 0; pos = 0; busy = 0;
            m_txen = 0; m_tri = 0; m_rx = 0; m_unb = 0; m_ovf = 0;
        end else begin
            int nb;
            bit done_now, acc, st;
            nb       = nine_bit ? 9 : 8;
            done_now = baud_tick && busy && (pos == nb + 1);
            acc      = wr_en && (q.size() == 0);
            if (wr_en && !acc) m_ovf = 1;
            m_unb = done_now && cur[11];
            if (done_now) begin
                if (cur[12]) m_tri = 1;
                if (cur[15]) m_rx = 1;
                if (cur[14]) m_txen = 0;
            end
            st = baud_tick && m_txen && (q.size() > 0) && (!busy || done_now);
            if (st) begin
                cur = q.pop_front(); pos = 0; busy = 1;
            end else if (done_now) begin
                busy = 0; pos = 0;
            end else if (baud_tick && busy) begin
                pos++;
            end
            if (acc) begin
                q.push_back(int'(wr_data[15:0]));
                q.push_back(int'(wr_data[31:16]));
            end
            if (tx_en_cmd) begin m_txen = 1; m_tri = 0; end
        end
    end

    function automatic logic exp_line();
        int nb;
        nb = nine_bit ? 9 : 8;
        if (!busy)            return 1'b1;
        if (pos == 0)         return 1'b0;
        if (pos == nb + 1)    return ~cur[13];
        return cur[pos-1];
    endfunction

    task automatic cmp(input string req, input string nm, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, nm, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (running && rst_n) begin
            cmp(line_req, "tx_line", tx_line, exp_line());
            cmp("R6", "tx_oe", tx_oe, m_txen && !m_tri);
            cmp("R9", "tx_en", tx_en, m_txen);
            cmp("R8", "rx_en", rx_en, m_rx);
            cmp("R7", "rx_unblock", rx_unblock, m_unb);
            cmp("R3", "overflow", overflow, m_ovf);
        end
    end

    // Baud tick: one cycle in four.
    always @(negedge clk) begin
        if (!rst_n) begin
            tick_cnt  <= 0;
            baud_tick <= 1'b0;
        end else begin
            tick_cnt  <= (tick_cnt + 1) % 4;
            baud_tick <= (tick_cnt == 3);
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_word(input logic [15:0] hi, input logic [15:0] lo);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = {hi, lo};
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic enable_tx();
        @(negedge clk);
        tx_en_cmd = 1'b1;
        @(negedge clk);
        tx_en_cmd = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        cmp("R1", "tx_line", tx_line, 1'b1);
        cmp("R1", "tx_oe", tx_oe, 1'b0);
        cmp("R1", "tx_en", tx_en, 1'b0);
        cmp("R1", "rx_en", rx_en, 1'b0);
        cmp("R1", "rx_unblock", rx_unblock, 1'b0);
        cmp("R1", "overflow", overflow, 1'b0);
        running = 1;

        // R2 enable command
        enable_tx();
        cmp("R2", "tx_en after cmd", tx_en, 1'b1);
        cmp("R2", "tx_oe after cmd", tx_oe, 1'b1);

        // R4/R10: two 8-bit frames back to back; high frame unblocks (R7) and enables RX (R8)
        line_req = "R10";
        write_word(16'h88A3, 16'h0055);
        // R3: second write while frames still queued is dropped
        write_word(16'h00FF, 16'h00FF);
        cmp("R3", "overflow after dropped write", overflow, 1'b1);
        wait_cyc(120);
        cmp("R8", "rx_en after frame", rx_en, 1'b1);

        // R4 nine-bit frame, then R5 break frame with all-zero data
        nine_bit = 1'b1;
        line_req = "R5";
        write_word(16'h2000, 16'h01C5);
        wait_cyc(130);
        nine_bit = 1'b0;

        // R11 reserved bits set; R6 tristate on the high frame
        line_req = "R11";
        write_word(16'h1681, 16'h063C);
        wait_cyc(120);
        cmp("R6", "tx_en after tristate", tx_en, 1'b1);
        cmp("R6", "tx_oe after tristate", tx_oe, 1'b0);
        enable_tx();
        cmp("R2", "tx_oe after re-enable", tx_oe, 1'b1);

        // R9 disable on the low frame; high frame must wait
        line_req = "R9";
        write_word(16'h0022, 16'h4011);
        wait_cyc(150);
        cmp("R9", "tx_en after disable", tx_en, 1'b0);
        cmp("R9", "tx_line idle while disabled", tx_line, 1'b1);
        enable_tx();
        wait_cyc(8);
        cmp("R9", "held frame started", tx_line, 1'b0);
        wait_cyc(60);
        cmp("R9", "line idle at end", tx_line, 1'b1);

        finish_run();
    end
endmodule